// File: doc/BRIEF.md
# Port Input Debouncer

This block cleans up four slow general-purpose input pins before the rest of the chip sees them. Each raw pin first passes through a two-flop synchronizer. A pin whose filter is switched on changes its output only after the synchronized level has differed from the current output on three sampling ticks in a row. Shorter bursts are thrown away as noise. A pin whose filter is switched off shows the synchronized level directly.

All four pins share one sampling-rate generator. It offers four rates: every system clock, every 4th clock, every 4096th clock, or each strobe on a tick input that comes from a low-speed oscillator and is already synchronous to the system clock. The rate and the per-pin filter switches are held in a single 8-bit configuration register with a write strobe and a read-back bus. A stop-mode flag turns filtering off on every pin while it is high. When the flag clears, filtering continues from whatever level the pins hold at that time.

Top module: `pin_debounce`

## Requirements
- R1: The configuration register resets to 00h. A write stores bits 7:2. Bits 1:0 always read as 0, and writes to them have no effect.
- R2: A pin whose enable bit is 0 drives its output with the synchronized raw level. A change on the raw pin appears on the output two clock edges later.
- R3: Bits 7:6 select the sampling rate: 00 samples on every clock, 01 on every 4th clock, 10 on every 4096th clock, and 11 on each cycle in which the low-speed tick input is high.
- R4: An enabled pin's output takes a new level on the third consecutive sampling tick on which the synchronized input differs from the output. At the every-clock rate, this is five clock edges after the raw change.
- R5: If the synchronized input returns to the output level before the third differing sample, the output does not change and the run count starts again from zero.
- R6: While stop_mode is high, every output follows its synchronized raw level. When stop_mode falls, filtering resumes from the current raw level with no spurious transition.
- R7: A write that changes bits 7:6 restarts the rate generator. The first sample at a divided rate then falls one full period after the write.
- R8: The enable in bit 2+k applies only to pin k (pins 0 to 3, bits 2 to 5). Filtered and bypassed pins work side by side.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read-back |
| lso_tick | input | 1 | One-cycle strobe from the low-speed oscillator, already synchronous to clk |
| stop_mode | input | 1 | High while the chip is in stop mode; forces all pins to bypass |
| pin_raw | input | 4 | Asynchronous raw pin levels |
| pin_filt | output | 4 | Debounced pin levels |

## Verification
The bench drives inputs on falling edges and counts rising edges to predict every output.
- **Bypassed pins:** a new raw level is due two edges after it is driven.
- **Every-clock rate:** a filtered change is due five edges after it is driven.
- **Divided rates:** after a sel-changing write at edge W, the first sample falls at W+4 or W+4096. The change is therefore due at W+12 or W+12288.
- **Low-speed tick rate:** the change is due on the edge that takes the third tick.

Each check samples the output on the falling edge just before the due edge, where the old value is expected, and again on the falling edge just after it, where the new value is expected. A result that is one cycle early or one cycle late therefore fails.

// File: rtl/pin_dbnc_pkg.sv
package pin_dbnc_pkg;
   typedef enum logic [1:0] {
      RATE_FULL = 2'b00,
      RATE_MID  = 2'b01,
      RATE_SLOW = 2'b10,
      RATE_LSO  = 2'b11
   } rate_sel_e;

   localparam int CFG_W   = 8;
   localparam int SEL_LSB = 6;
   localparam int SEL_W   = 2;
   localparam int EN_LSB  = 2;
   localparam int EN_W    = 4;
endpackage

// File: rtl/dbnc_rate_gen.sv
module dbnc_rate_gen
   import pin_dbnc_pkg::*;
#(
   parameter int DIV_MID  = 4,
   parameter int DIV_SLOW = 4096
) (
   input  logic      clk,
   input  logic      rst_n,
   input  rate_sel_e sel,
   input  logic      restart,
   input  logic      lso_tick,
   output logic      tick
);
   localparam int CW = $clog2(DIV_SLOW);

   if (DIV_MID < 2) begin : g_bad_mid
      $error("DIV_MID must be at least 2");
   end
   if (DIV_SLOW <= DIV_MID) begin : g_bad_slow
      $error("DIV_SLOW must exceed DIV_MID");
   end

   logic [CW-1:0] cnt;
   logic [CW-1:0] limit;
   logic          wrap;

   always_comb begin
      case (sel)
         RATE_MID:  limit = CW'(DIV_MID - 1);
         RATE_SLOW: limit = CW'(DIV_SLOW - 1);
         default:   limit = '0;
      endcase
   end

   assign wrap = (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt <= '0;
      else if (restart || sel == RATE_LSO) cnt <= '0;
      else if (wrap)                      cnt <= '0;
      else                                cnt <= cnt + 1'b1;
   end

   assign tick = (sel == RATE_LSO) ? lso_tick : wrap;

   AST_MID_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == RATE_MID && $past(sel) == RATE_MID && !$past(restart) && $past(tick)) |-> !tick); // R3
   AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(restart) && (sel == RATE_MID || sel == RATE_SLOW)) |-> !tick); // R7
endmodule

// File: rtl/dbnc_lane.sv
module dbnc_lane #(
   parameter int SYNC_STAGES = 2,
   parameter int CONFIRM     = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_raw,
   input  logic sample,
   input  logic active,
   output logic pin_out
);
   localparam int CW = $clog2(CONFIRM);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (CONFIRM < 2) begin : g_bad_confirm
      $error("CONFIRM must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;
   logic                   held;
   logic [CW-1:0]          run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_raw};
   end
   assign synced = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held <= 1'b0;
         run  <= '0;
      end else if (!active) begin
         held <= synced;
         run  <= '0;
      end else if (sample) begin
         if (synced == held) begin
            run <= '0;
         end else if (run == CW'(CONFIRM - 1)) begin
            held <= ~held;
            run  <= '0;
         end else begin
            run <= run + 1'b1;
         end
      end
   end

   assign pin_out = active ? held : synced;

   AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(active) && !$past(sample)) |-> $stable(held)); // R4
   AST_TOGGLE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(active) && held != $past(held)) |-> ($past(run) == CW'(CONFIRM - 1))); // R5
   AST_IDLE_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!active) |-> (run == '0)); // R6
endmodule

// File: rtl/pin_debounce.sv
module pin_debounce
   import pin_dbnc_pkg::*;
#(
   parameter int NUM_PINS    = 4,
   parameter int DIV_MID     = 4,
   parameter int DIV_SLOW    = 4096,
   parameter int SYNC_STAGES = 2,
   parameter int CONFIRM     = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_wr,
   input  logic [CFG_W-1:0]    cfg_wdata,
   output logic [CFG_W-1:0]    cfg_rdata,
   input  logic                lso_tick,
   input  logic                stop_mode,
   input  logic [NUM_PINS-1:0] pin_raw,
   output logic [NUM_PINS-1:0] pin_filt
);
   if (NUM_PINS < 1 || NUM_PINS > EN_W) begin : g_bad_pins
      $error("NUM_PINS must be between 1 and EN_W");
   end

   rate_sel_e       sel_q;
   logic [EN_W-1:0] en_q;
   logic            restart;
   logic            tick;
   logic            unused_low;

   assign unused_low = ^cfg_wdata[EN_LSB-1:0];
   assign restart    = cfg_wr && (cfg_wdata[SEL_LSB +: SEL_W] != sel_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= RATE_FULL;
         en_q  <= '0;
      end else if (cfg_wr) begin
         sel_q <= rate_sel_e'(cfg_wdata[SEL_LSB +: SEL_W]);
         en_q  <= cfg_wdata[EN_LSB +: EN_W];
      end
   end

   assign cfg_rdata = {sel_q, en_q, {EN_LSB{1'b0}}};

   dbnc_rate_gen #(
      .DIV_MID  (DIV_MID),
      .DIV_SLOW (DIV_SLOW)
   ) u_rate (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (sel_q),
      .restart  (restart),
      .lso_tick (lso_tick),
      .tick     (tick)
   );

   for (genvar k = 0; k < NUM_PINS; k++) begin : g_lane
      dbnc_lane #(
         .SYNC_STAGES (SYNC_STAGES),
         .CONFIRM     (CONFIRM)
      ) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .pin_raw (pin_raw[k]),
         .sample  (tick),
         .active  (en_q[k] && !stop_mode),
         .pin_out (pin_filt[k])
      );
   end

   AST_CFG_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_wr) |-> (cfg_rdata[CFG_W-1:EN_LSB] == $past(cfg_wdata[CFG_W-1:EN_LSB]))); // R1
endmodule

// File: tb/pin_debounce_bench.sv
module pin_debounce_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [7:0] cfg_wdata = 8'h00;
   logic [7:0] cfg_rdata;
   logic       lso_tick = 1'b0;
   logic       stop_mode = 1'b0;
   logic [3:0] pin_raw = 4'h0;
   logic [3:0] pin_filt;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pin_debounce u_pin_debounce (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .lso_tick  (lso_tick),
      .stop_mode (stop_mode),
      .pin_raw   (pin_raw),
      .pin_filt  (pin_filt)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cfg_write(input logic [7:0] d);
      cfg_wr = 1'b1;
      cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic settle();
      stop_mode = 1'b0;
      pin_raw = 4'h0;
      cfg_write(8'h00);
      wait_n(4);
   endtask

   task automatic t_reset();
      chk("R1 reset read", cfg_rdata, 8'h00);
      chk("R1 reset out", {4'h0, pin_filt}, 8'h00);
   endtask

   task automatic t_register();
      cfg_write(8'hFF);
      chk("R1 low bits masked", cfg_rdata, 8'hFC);
      cfg_write(8'h03);
      chk("R1 low bits ignored", cfg_rdata, 8'h00);
   endtask

   task automatic t_bypass();
      settle();
      pin_raw = 4'b1010;
      wait_n(1);
      chk("R2 bypass before", {4'h0, pin_filt}, 8'h00);
      wait_n(1);
      chk("R2 bypass after", {4'h0, pin_filt}, 8'h0A);
   endtask

   task automatic t_filter_basic();
      settle();
      cfg_write(8'h3C);
      wait_n(3);
      pin_raw = 4'hF;
      wait_n(4);
      chk("R4 rise early", {4'h0, pin_filt}, 8'h00);
      wait_n(1);
      chk("R4 rise due", {4'h0, pin_filt}, 8'h0F);
      pin_raw = 4'h0;
      wait_n(4);
      chk("R4 fall early", {4'h0, pin_filt}, 8'h0F);
      wait_n(1);
      chk("R4 fall due", {4'h0, pin_filt}, 8'h00);
   endtask

   task automatic t_glitch();
      bit moved = 1'b0;
      settle();
      cfg_write(8'h3C);
      wait_n(3);
      pin_raw = 4'h1;
      wait_n(2);
      pin_raw = 4'h0;
      for (int i = 0; i < 8; i++) begin
         wait_n(1);
         if (pin_filt !== 4'h0) moved = 1'b1;
      end
      chk("R5 short pulse dropped", {7'h0, moved}, 8'h00);
      pin_raw = 4'h1;
      wait_n(3);
      pin_raw = 4'h0;
      wait_n(1);
      chk("R5 long pulse early", {4'h0, pin_filt}, 8'h00);
      wait_n(1);
      chk("R5 long pulse kept", {4'h0, pin_filt}, 8'h01);
      wait_n(6);
   endtask

   task automatic t_independent();
      settle();
      cfg_write(8'h04);
      wait_n(3);
      pin_raw = 4'hF;
      wait_n(2);
      chk("R8 bypass lanes first", {4'h0, pin_filt}, 8'h0E);
      wait_n(2);
      chk("R8 filtered lane waits", {4'h0, pin_filt}, 8'h0E);
      wait_n(1);
      chk("R8 filtered lane due", {4'h0, pin_filt}, 8'h0F);
   endtask

   task automatic t_stop();
      bit moved = 1'b0;
      settle();
      cfg_write(8'h3C);
      wait_n(3);
      stop_mode = 1'b1;
      pin_raw = 4'b0101;
      wait_n(2);
      chk("R6 stop follows raw", {4'h0, pin_filt}, 8'h05);
      wait_n(1);
      stop_mode = 1'b0;
      for (int i = 0; i < 6; i++) begin
         #1;
         if (pin_filt !== 4'b0101) moved = 1'b1;
         wait_n(1);
      end
      chk("R6 resume from raw", {7'h0, moved}, 8'h00);
      pin_raw = 4'h0;
      wait_n(4);
      chk("R6 filtering back early", {4'h0, pin_filt}, 8'h05);
      wait_n(1);
      chk("R6 filtering back due", {4'h0, pin_filt}, 8'h00);
   endtask

   task automatic t_rate_mid();
      settle();
      cfg_write(8'h7C);
      pin_raw = 4'hF;
      wait_n(11);
      chk("R3 div4 early", {4'h0, pin_filt}, 8'h00);
      wait_n(1);
      chk("R3 div4 due", {4'h0, pin_filt}, 8'h0F);
   endtask

   task automatic t_rate_slow();
      settle();
      cfg_write(8'hBC);
      pin_raw = 4'hF;
      wait_n(3 * 4096 - 1);
      chk("R3 div4096 early", {4'h0, pin_filt}, 8'h00);
      wait_n(1);
      chk("R3 div4096 due", {4'h0, pin_filt}, 8'h0F);
   endtask

   task automatic t_restart();
      settle();
      cfg_write(8'hBC);
      wait_n(5);
      cfg_write(8'h7C);
      pin_raw = 4'hF;
      wait_n(11);
      chk("R7 restart early", {4'h0, pin_filt}, 8'h00);
      wait_n(1);
      chk("R7 restart due", {4'h0, pin_filt}, 8'h0F);
   endtask

   task automatic t_lso();
      settle();
      cfg_write(8'hFC);
      pin_raw = 4'hF;
      wait_n(20);
      chk("R3 lso no tick", {4'h0, pin_filt}, 8'h00);
      for (int i = 0; i < 2; i++) begin
         lso_tick = 1'b1;
         wait_n(1);
         lso_tick = 1'b0;
         wait_n(3);
      end
      chk("R3 lso two ticks", {4'h0, pin_filt}, 8'h00);
      lso_tick = 1'b1;
      wait_n(1);
      lso_tick = 1'b0;
      chk("R3 lso third tick", {4'h0, pin_filt}, 8'h0F);
   endtask

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);
      t_reset();
      t_register();
      t_bypass();
      t_filter_basic();
      t_glitch();
      t_independent();
      t_stop();
      t_rate_mid();
      t_rate_slow();
      t_restart();
      t_lso();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule